// File: doc/BRIEF.md
# I2C Serial Memory Slave Controller

This block is the bus-side protocol engine of a serial byte memory holding 2048 locations of 8 bits. A fast system clock oversamples the SCL and SDA pins through two-flop synchronizers. Edge logic on the synchronized lines finds START, repeated START and STOP conditions. A byte-level state machine receives the slave address byte, any word address and any data bytes, and transmits read data. The slave pulls SDA low through an open-drain output-enable. It never drives SDA high.

The three high memory address bits travel in the slave address byte. One 11-bit address pointer is shared by reads and writes and keeps its value between transactions. Written bytes are handed one at a time to an external page buffer, and a STOP tells that buffer to start programming. While the external write engine reports busy, the slave ignores its own address, so a master can poll for completion by repeating the address byte until it is acknowledged.

Top module: `i2c_mem_slave`

## Requirements
- R1: After reset, sda_oe_o, wr_stb_o and wr_commit_o are all low.
- R2: A slave address byte, sent MSB first, whose bits 7..4 equal 1010 is acknowledged: sda_oe_o is held high through the ninth SCL pulse. A byte with any other bits 7..4 gets no acknowledge, and the rest of that transaction is ignored up to the next START or STOP. Bit 0 of the byte selects read (1) or write (0).
- R3: sda_oe_o changes only in the cycle after a detected SCL falling edge, or in the cycle after a detected START or STOP. It is therefore steady while SCL is high.
- R4: In a write transaction, the byte after the slave address is acknowledged. It sets the pointer: its value becomes pointer bits 7..0, and bits 3..1 of that transaction's slave address byte become pointer bits 10..8. Each following byte is acknowledged and produces a one-cycle wr_stb_o carrying the pointer in wr_addr_o and the byte in wr_data_o.
- R5: After each written data byte, pointer bits 3..0 increment modulo 16 and bits 10..4 stay unchanged. A page write therefore wraps within its 16-byte page.
- R6: A STOP that ends a transaction with at least one data byte written pulses wr_commit_o for one cycle. Transactions that only read or only set the address produce no pulse.
- R7: A read transaction sends, MSB first, the byte at the current pointer. The three address bits in a read slave byte are ignored. After the eighth bit of each sent byte, the pointer increments over all 11 bits and rolls over from 2047 to 0.
- R8: After a sent byte, a master acknowledge (SDA low on the ninth pulse) starts the next byte. A master no-acknowledge makes the slave release SDA and ignore further pulses until START or STOP.
- R9: A repeated START after a write transaction that carried only the word address keeps the pointer, so the next read returns the addressed byte (random read).
- R10: While busy_i is high when the slave address byte completes, that byte is not acknowledged and the transaction is ignored.
- R11: A START in the middle of a byte aborts the transfer and returns to slave-address reception. The partial byte is not written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock, much faster than SCL |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL pin level |
| sda_i | input | 1 | SDA pin level (wired bus) |
| sda_oe_o | output | 1 | 1 pulls SDA low; 0 releases it |
| mem_addr_o | output | 11 | Read address, equal to the pointer |
| mem_rdata_i | input | 8 | Memory byte at mem_addr_o, same cycle |
| wr_stb_o | output | 1 | One-cycle strobe for a received data byte |
| wr_addr_o | output | 11 | Address for the byte under wr_stb_o |
| wr_data_o | output | 8 | Data under wr_stb_o |
| wr_commit_o | output | 1 | One-cycle pulse: start programming the buffered page |
| busy_i | input | 1 | Write engine busy with an internal cycle |

## Verification
Single-byte and page writes are checked against a bench memory. They show that the pointer is loaded from both the slave byte and the word byte, and that a page write wraps at its 16-byte boundary and leaves the next page alone. Current-address, random and sequential reads, including a read that crosses from 2047 to 0, show that the pointer persists between transactions and increments across all 11 bits. A wrong device code, a busy write engine, a master no-acknowledge and a START in the middle of a data byte each show that the slave stays silent or discards the partial byte, as seen on SDA, on the write strobes and on the data read back afterwards.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [3:0] {
    S_IDLE,
    S_DEV,
    S_DEV_ACK,
    S_ADR,
    S_ADR_ACK,
    S_WDAT,
    S_WDAT_ACK,
    S_RDAT,
    S_RACK,
    S_SKIP
  } st_e;
endpackage

// File: rtl/i2cm_line_sync.sv
module i2cm_line_sync #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned LINES  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LINES-1:0] d_i,
  output logic [LINES-1:0] q_o
);
  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES-1:0] chain;
    // idle bus level is high
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain <= '1;
      else         chain <= {chain[STAGES-2:0], d_i[g]};
    end
    assign q_o[g] = chain[STAGES-1];
  end
endmodule

// File: rtl/i2cm_cond_det.sv
module i2cm_cond_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_s_i,
  input  logic sda_s_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s_i;
      sda_q <= sda_s_i;
    end
  end

  assign scl_rise_o = scl_s_i & ~scl_q;
  assign scl_fall_o = ~scl_s_i & scl_q;
  // SDA edge while SCL held high
  assign start_o    = scl_s_i & scl_q & sda_q & ~sda_s_i;
  assign stop_o     = scl_s_i & scl_q & ~sda_q & sda_s_i;
endmodule

// File: rtl/i2cm_addr_ptr.sv
module i2cm_addr_ptr #(
  parameter int unsigned ADDR_W = 11,
  parameter int unsigned PAGE_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_i,
  input  logic [ADDR_W-1:0] ld_val_i,
  input  logic              inc_page_i,
  input  logic              inc_full_i,
  output logic [ADDR_W-1:0] ptr_o
);
  logic [ADDR_W-1:0] ptr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         ptr <= '0;
    else if (ld_i)       ptr <= ld_val_i;
    else if (inc_page_i) ptr <= {ptr[ADDR_W-1:PAGE_W], ptr[PAGE_W-1:0] + 1'b1};
    else if (inc_full_i) ptr <= ptr + 1'b1;
  end

  assign ptr_o = ptr;
endmodule

// File: rtl/i2c_mem_slave.sv
module i2c_mem_slave
  import i2cm_pkg::*;
#(
  parameter int unsigned ADDR_W      = 11,
  parameter int unsigned PAGE_W      = 4,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [3:0]  DEV_ID      = 4'b1010
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [7:0]        mem_rdata_i,
  output logic              wr_stb_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [7:0]        wr_data_o,
  output logic              wr_commit_o,
  input  logic              busy_i
);
  localparam int unsigned HI_W = ADDR_W - BYTE_W;

  logic [1:0] syn;
  logic       scl_s, sda_s;
  logic       scl_rise, scl_fall, start_det, stop_det, ev;

  i2cm_line_sync #(.STAGES(SYNC_STAGES), .LINES(2)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({scl_i, sda_i}),
    .q_o    (syn)
  );
  assign scl_s = syn[1];
  assign sda_s = syn[0];

  i2cm_cond_det i_cond (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_s_i    (scl_s),
    .sda_s_i    (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_det),
    .stop_o     (stop_det)
  );
  assign ev = start_det | stop_det;

  st_e               st;
  logic [3:0]        cnt;
  logic [7:0]        sr;
  logic              oe, rw_q, mack_q, have_data;
  logic [HI_W-1:0]   hi_q;
  logic              stb_q, commit_q;
  logic [ADDR_W-1:0] waddr_q;
  logic [7:0]        wdata_q;
  logic [ADDR_W-1:0] ptr;

  logic rx_state, rx_done, dev_done, adr_done, wdat_done, tx_done;

  assign rx_state  = (st == S_DEV) || (st == S_ADR) || (st == S_WDAT);
  assign rx_done   = rx_state && scl_fall && (cnt == 4'd8) && !ev;
  assign dev_done  = rx_done && (st == S_DEV);
  assign adr_done  = rx_done && (st == S_ADR);
  assign wdat_done = rx_done && (st == S_WDAT);
  assign tx_done   = (st == S_RDAT) && scl_fall && (cnt == 4'd7) && !ev;

  i2cm_addr_ptr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) i_ptr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ld_i       (adr_done),
    .ld_val_i   ({hi_q, sr}),
    .inc_page_i (wdat_done),
    .inc_full_i (tx_done),
    .ptr_o      (ptr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st        <= S_IDLE;
      cnt       <= '0;
      sr        <= '0;
      oe        <= 1'b0;
      rw_q      <= 1'b0;
      mack_q    <= 1'b0;
      have_data <= 1'b0;
      hi_q      <= '0;
      stb_q     <= 1'b0;
      commit_q  <= 1'b0;
      waddr_q   <= '0;
      wdata_q   <= '0;
    end else begin
      stb_q    <= 1'b0;
      commit_q <= 1'b0;
      if (start_det) begin
        st  <= S_DEV;
        cnt <= '0;
        oe  <= 1'b0;
      end else if (stop_det) begin
        st        <= S_IDLE;
        oe        <= 1'b0;
        commit_q  <= have_data;
        have_data <= 1'b0;
      end else begin
        unique case (st)
          S_DEV, S_ADR, S_WDAT: begin
            if (scl_rise && cnt != 4'd8) begin
              sr  <= {sr[6:0], sda_s};
              cnt <= cnt + 4'd1;
            end
            if (dev_done) begin
              cnt <= '0;
              if (sr[7:4] == DEV_ID && !busy_i) begin
                oe   <= 1'b1;
                rw_q <= sr[0];
                if (!sr[0]) hi_q <= sr[HI_W:1];
                st   <= S_DEV_ACK;
              end else begin
                st <= S_SKIP;
              end
            end else if (adr_done) begin
              cnt <= '0;
              oe  <= 1'b1;
              st  <= S_ADR_ACK;
            end else if (wdat_done) begin
              cnt       <= '0;
              oe        <= 1'b1;
              st        <= S_WDAT_ACK;
              stb_q     <= 1'b1;
              waddr_q   <= ptr;
              wdata_q   <= sr;
              have_data <= 1'b1;
            end
          end
          S_DEV_ACK: begin
            if (scl_fall) begin
              cnt <= '0;
              if (rw_q) begin
                st <= S_RDAT;
                sr <= mem_rdata_i;
                oe <= ~mem_rdata_i[7];
              end else begin
                st <= S_ADR;
                oe <= 1'b0;
              end
            end
          end
          S_ADR_ACK, S_WDAT_ACK: begin
            if (scl_fall) begin
              cnt <= '0;
              oe  <= 1'b0;
              st  <= S_WDAT;
            end
          end
          S_RDAT: begin
            if (tx_done) begin
              oe     <= 1'b0;
              mack_q <= 1'b0;
              st     <= S_RACK;
            end else if (scl_fall) begin
              cnt <= cnt + 4'd1;
              sr  <= {sr[6:0], 1'b0};
              oe  <= ~sr[6];
            end
          end
          S_RACK: begin
            if (scl_rise) mack_q <= ~sda_s;
            if (scl_fall) begin
              if (mack_q) begin
                st  <= S_RDAT;
                cnt <= '0;
                sr  <= mem_rdata_i;
                oe  <= ~mem_rdata_i[7];
              end else begin
                st <= S_SKIP;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe_o    = oe;
  assign mem_addr_o  = ptr;
  assign wr_stb_o    = stb_q;
  assign wr_addr_o   = waddr_q;
  assign wr_data_o   = wdata_q;
  assign wr_commit_o = commit_q;
endmodule

// File: rtl/i2cm_slave_chk.sv
module i2cm_slave_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic scl_fall,
  input logic start_det,
  input logic stop_det,
  input logic dev_done,
  input logic busy_i,
  input logic sda_oe_o,
  input logic wr_stb_o,
  input logic wr_commit_o
);
  a_r3_oe_moves_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $changed(sda_oe_o) |-> ($past(scl_fall) || $past(start_det) || $past(stop_det)));

  a_r10_busy_no_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dev_done && busy_i) |=> !sda_oe_o);

  a_r4_stb_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stb_o |=> !wr_stb_o);

  a_r4_stb_after_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stb_o |-> $past(scl_fall));

  a_r6_commit_after_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_commit_o |-> $past(stop_det));

  a_r11_cond_releases: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_det || stop_det) |=> !sda_oe_o);
endmodule

bind i2c_mem_slave i2cm_slave_chk i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .scl_fall    (scl_fall),
  .start_det   (start_det),
  .stop_det    (stop_det),
  .dev_done    (dev_done),
  .busy_i      (busy_i),
  .sda_oe_o    (sda_oe_o),
  .wr_stb_o    (wr_stb_o),
  .wr_commit_o (wr_commit_o)
);

// File: tb/test_i2c_mem_slave.sv
module test_i2c_mem_slave;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scl_m = 1'b1, sda_m = 1'b1, busy = 1'b0;
  logic        sda_oe, wr_stb, wr_commit, sda_line;
  logic [10:0] mem_addr, wr_addr;
  logic [7:0]  mem_rdata, wr_data;
  logic [7:0]  mem [0:2047];
  int          n_vec = 0, n_err = 0, n_stb = 0, n_commit = 0;

  always #2 clk = ~clk;

  assign sda_line  = sda_m & ~sda_oe;
  assign mem_rdata = mem[mem_addr];

  i2c_mem_slave i_i2c_mem_slave (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .scl_i       (scl_m),
    .sda_i       (sda_line),
    .sda_oe_o    (sda_oe),
    .mem_addr_o  (mem_addr),
    .mem_rdata_i (mem_rdata),
    .wr_stb_o    (wr_stb),
    .wr_addr_o   (wr_addr),
    .wr_data_o   (wr_data),
    .wr_commit_o (wr_commit),
    .busy_i      (busy)
  );

  always @(posedge clk) begin
    if (wr_stb) begin
      mem[wr_addr] <= wr_data;
      n_stb <= n_stb + 1;
    end
    if (wr_commit) n_commit <= n_commit + 1;
  end

  function automatic logic [7:0] initv(input int a);
    return 8'((a * 7 + 3) ^ (a >> 8));
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic ph;
    repeat (20) @(negedge clk);
  endtask

  task automatic start_c;
    sda_m = 1'b1; ph; scl_m = 1'b1; ph; sda_m = 1'b0; ph; scl_m = 1'b0; ph;
  endtask

  task automatic stop_c;
    sda_m = 1'b0; ph; scl_m = 1'b1; ph; sda_m = 1'b1; ph;
  endtask

  task automatic tx_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; ph; scl_m = 1'b1; ph; scl_m = 1'b0; ph;
    end
  endtask

  task automatic tx_byte(input logic [7:0] b, output logic ack);
    tx_bits(b, 8);
    sda_m = 1'b1; ph; scl_m = 1'b1; ph; ack = sda_line; scl_m = 1'b0; ph;
  endtask

  task automatic rx_byte(input logic mack, output logic [7:0] b);
    logic late;
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1'b1; ph; scl_m = 1'b1;
      repeat (10) @(negedge clk);
      b[i] = sda_line;
      repeat (9) @(negedge clk);
      late = sda_line;
      check("R3 data steady while SCL high", late, b[i]);
      @(negedge clk);
      scl_m = 1'b0; ph;
    end
    sda_m = ~mack; ph; scl_m = 1'b1; ph; scl_m = 1'b0; ph; sda_m = 1'b1;
  endtask

  task automatic t_reset;
    check("R1 sda_oe after reset", sda_oe, 0);
    check("R1 wr_stb after reset", n_stb, 0);
    check("R1 wr_commit after reset", n_commit, 0);
  endtask

  task automatic t_byte_write;
    logic a;
    start_c;
    tx_byte(8'hA0, a); check("R2 address ack", a, 0);
    tx_byte(8'h10, a); check("R4 word address ack", a, 0);
    tx_byte(8'h5A, a); check("R4 data ack", a, 0);
    stop_c; ph;
    check("R4 byte written", mem[11'h010], 8'h5A);
    check("R6 commit after write", n_commit, 1);
  endtask

  task automatic t_bad_id;
    logic a;
    start_c;
    tx_byte(8'hB0, a); check("R2 foreign code no ack", a, 1);
    tx_byte(8'h10, a);
    tx_byte(8'h77, a); check("R2 ignored byte no ack", a, 1);
    stop_c; ph;
    check("R2 ignored data not written", mem[11'h010], 8'h5A);
    check("R2 no strobe", n_stb, 1);
  endtask

  task automatic t_page_write;
    logic a;
    start_c;
    tx_byte(8'hAA, a); check("R4 high bits address ack", a, 0);
    tx_byte(8'h3E, a);
    tx_byte(8'h11, a); tx_byte(8'h22, a); tx_byte(8'h33, a); tx_byte(8'h44, a);
    stop_c; ph;
    check("R4 page byte 0", mem[11'h53E], 8'h11);
    check("R5 page byte 1", mem[11'h53F], 8'h22);
    check("R5 wrap byte 2", mem[11'h530], 8'h33);
    check("R5 wrap byte 3", mem[11'h531], 8'h44);
    check("R5 next page untouched", mem[11'h540], initv(11'h540));
    check("R6 second commit", n_commit, 2);
  endtask

  task automatic t_cur_read;
    logic a;
    logic [7:0] d;
    start_c;
    tx_byte(8'hA1, a); check("R7 read address ack", a, 0);
    rx_byte(1'b0, d); check("R7 current address read", d, initv(11'h532));
    rx_byte(1'b0, d); check("R8 silent after nack", d, 8'hFF);
    stop_c; ph;
    check("R6 no commit on read", n_commit, 2);
  endtask

  task automatic t_random;
    logic a;
    logic [7:0] d;
    start_c;
    tx_byte(8'hA0, a); tx_byte(8'h10, a);
    start_c;
    tx_byte(8'hA1, a); check("R9 read after restart ack", a, 0);
    rx_byte(1'b1, d); check("R9 random read", d, 8'h5A);
    rx_byte(1'b0, d); check("R8 sequential after ack", d, initv(11'h011));
    stop_c; ph;
    check("R6 no commit on address only", n_commit, 2);
  endtask

  task automatic t_roll;
    logic a;
    logic [7:0] d;
    start_c;
    tx_byte(8'hAE, a); tx_byte(8'hFF, a);
    start_c;
    tx_byte(8'hA1, a);
    rx_byte(1'b1, d); check("R7 top address", d, initv(11'h7FF));
    rx_byte(1'b0, d); check("R7 rollover to zero", d, initv(11'h000));
    stop_c; ph;
  endtask

  task automatic t_busy;
    logic a;
    logic [7:0] d;
    busy = 1'b1;
    start_c;
    tx_byte(8'hA0, a); check("R10 no ack while busy", a, 1);
    stop_c; ph;
    busy = 1'b0;
    start_c;
    tx_byte(8'hA1, a); check("R10 ack when idle", a, 0);
    rx_byte(1'b0, d); check("R10 pointer kept", d, initv(11'h001));
    stop_c; ph;
  endtask

  task automatic t_abort;
    logic a;
    logic [7:0] d;
    start_c;
    tx_byte(8'hA0, a); tx_byte(8'h20, a);
    tx_bits(8'hF0, 4);
    start_c;
    tx_byte(8'hA1, a); check("R11 address after abort ack", a, 0);
    rx_byte(1'b0, d); check("R11 partial byte discarded", d, initv(11'h020));
    stop_c; ph;
    check("R11 no strobe on partial byte", n_stb, 5);
  endtask

  initial begin
    for (int i = 0; i < 2048; i++) mem[i] = initv(i);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset;
    t_byte_write;
    t_bad_id;
    t_page_write;
    t_cur_read;
    t_random;
    t_roll;
    t_busy;
    t_abort;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_vec++;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end
endmodule